// File: doc/BRIEF.md
# CAN Bit Timing Sampler

This block sits between a CAN receive pin and a bit-stream decoder. It divides the system clock into time quanta (Tq) and walks every bit time through its four segments in a fixed order. The segments are a one-Tq synchronization segment, a propagation segment, phase segment 1 and phase segment 2. At the sample point, which is the last Tq of phase segment 1, it takes the line level. When three-sample mode is chosen, it instead takes a majority vote over the level at the sample point and the levels one and two Tq earlier. Once per bit it hands the decided value to the decoder.

After the block is released from its held state, it stays not-ready until the bus has shown a run of eleven recessive bits in a row. Until then, and whenever the bus is idle, a falling edge on the line restarts the bit at its synchronization segment (hard synchronization). The output side is a plain strobe with no back-pressure: the line cannot be paused, so the decoder must accept every `bit_vld` pulse. The value stays on `bit_val` until the next pulse, which gives the decoder a full bit time to take it. Phase re-alignment with a jump width, frame decoding and transmission are left to other blocks.

Top module: `can_bit_sampler`

## Requirements
- R1: One Tq lasts `presc`+1 clocks, and one bit lasts 1+`prop_seg`+`ph1_seg`+`ph2_seg` Tq. On a steady line, successive `bit_vld` pulses are exactly that many clocks apart.
- R2: While `rst_n` is low or `run` is low, the Tq and segment counters are held at zero, `bus_ready` and the recessive-bit count are cleared, `bit_vld` and `smp_stb` stay low, and `bit_val` reads 1 (recessive).
- R3: With `triple_sel`=0, the bit value is the synchronized line level in the last Tq of phase segment 1. Recessive is 1 and dominant is 0.
- R4: With `triple_sel`=1, the bit value is the majority of three line captures: one in the last Tq of phase segment 1, one in the Tq before it and one in the Tq two before it.
- R5: When `prop_seg`+`ph1_seg` is below 3, `triple_sel`=1 is ignored and the single-sample rule of R3 is used.
- R6: `smp_stb` is a one-clock pulse at the end of the sample-point Tq. Suppose a hard synchronization is triggered by a line fall that the first synchronizer flop captures at clock edge k, and let P=`presc`+1. Then `smp_stb` is high in the cycle after edge k+2+(`prop_seg`+`ph1_seg`+1)·P.
- R7: `bit_vld` is a one-clock pulse at the end of phase segment 2, in the cycle after edge k+2+N·P for the bit that starts at a hard synchronization, where N is the bit length in Tq. `bit_val` changes only together with a `bit_vld` pulse, or when the block is held.
- R8: `bus_ready` rises in the same cycle as the `bit_vld` pulse of the 11th consecutive recessive bit after release. It then stays high until the block is held again.
- R9: A dominant bit before ready restarts the recessive count, so 11 further recessive bits are needed.
- R10: A falling edge on the synchronized line triggers a hard synchronization only while not ready, or while ready with at least 11 recessive bits since the last dominant one. Otherwise the edge leaves the bit timing untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | 1 = operate; 0 = hold in reset state (release control) |
| rx_in | input | 1 | Raw receive line, 1 = recessive |
| presc | input | PRESC_W | Tq length minus one, in clocks |
| prop_seg | input | SEG_W | Propagation segment length in Tq |
| ph1_seg | input | SEG_W | Phase segment 1 length in Tq (at least 1) |
| ph2_seg | input | SEG_W | Phase segment 2 length in Tq (at least 1) |
| triple_sel | input | 1 | 1 = three-sample majority, 0 = single sample |
| bit_val | output | 1 | Decided bit value, held between strobes |
| bit_vld | output | 1 | One-clock pulse per completed bit |
| smp_stb | output | 1 | One-clock pulse at the sample point |
| bus_ready | output | 1 | Eleven recessive bits seen since release |

## Verification
Two functions can land in the same clock edge. The first is the strobe of a completed bit. The second is the ready decision, or the idle test that gates hard synchronization. The bench provokes the first case by releasing the block onto a recessive line. It then judges the ready flag as sampled at the 10th and 11th strobe, which must read low and then high. For the second case, the bench starts a frame with a dominant bit right after the bus has been idle. It places glitches on later bits that would realign the timing if a hard synchronization were wrongly allowed. The strobe spacing and the decided values must then show that no realignment took place.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;

  localparam int unsigned IDLE_RUN_DEF = 11;
  localparam int unsigned MIN_TRIPLE_SPAN = 3;

  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/can_bt_sync.sv
module can_bt_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_raw,
  output logic rx_s,
  output logic rx_fall
);
  logic [STAGES-1:0] chain;
  logic              rx_prev;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b1;
          else        chain[0] <= rx_raw;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[g] <= 1'b1;
          else        chain[g] <= chain[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rx_prev <= 1'b1;
    else        rx_prev <= chain[STAGES-1];

  assign rx_s    = chain[STAGES-1];
  assign rx_fall = rx_prev & ~chain[STAGES-1];
endmodule

// File: rtl/can_bt_tq_gen.sv
module can_bt_tq_gen #(
  parameter int unsigned PRESC_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               hsync,
  input  logic [PRESC_W-1:0] presc,
  output logic               tq_tick
);
  logic [PRESC_W-1:0] pcnt;

  assign tq_tick = run && !hsync && (pcnt >= presc);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                        pcnt <= '0;
    else if (!run || hsync || tq_tick) pcnt <= '0;
    else                               pcnt <= pcnt + 1'b1;

  // R1: with a prescaler above zero, quanta never tick back to back
  assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tq_tick && presc != '0) |=> !tq_tick);
endmodule

// File: rtl/can_bt_seq.sv
module can_bt_seq #(
  parameter int unsigned SEG_W = 4,
  parameter int unsigned TQ_W  = SEG_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             hsync,
  input  logic             tq_tick,
  input  logic [SEG_W-1:0] prop_seg,
  input  logic [SEG_W-1:0] ph1_seg,
  input  logic [SEG_W-1:0] ph2_seg,
  output logic             cap_far,
  output logic             cap_near,
  output logic             samp_ev,
  output logic             bit_end,
  output logic             span_ok
);
  logic [TQ_W-1:0] tq_idx;
  logic [TQ_W-1:0] sp_idx;
  logic [TQ_W-1:0] last_idx;

  assign sp_idx   = TQ_W'(prop_seg) + TQ_W'(ph1_seg);
  assign last_idx = sp_idx + TQ_W'(ph2_seg);
  assign span_ok  = sp_idx >= TQ_W'(can_bt_pkg::MIN_TRIPLE_SPAN);

  assign samp_ev  = tq_tick && (tq_idx == sp_idx);
  assign cap_near = tq_tick && (tq_idx == sp_idx - TQ_W'(1));
  assign cap_far  = tq_tick && (tq_idx == sp_idx - TQ_W'(2));
  assign bit_end  = tq_tick && (tq_idx >= last_idx);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)              tq_idx <= '0;
    else if (!run || hsync)  tq_idx <= '0;
    else if (bit_end)        tq_idx <= '0;
    else if (tq_tick)        tq_idx <= tq_idx + 1'b1;

  // R1: a finished bit always restarts at the synchronization segment
  assert_wrap_to_sync_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bit_end |=> (tq_idx == '0));
  // R6: the sample point lies strictly before the end of the bit
  assert_sample_before_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_ev && ph2_seg != '0) |-> !bit_end);
endmodule

// File: rtl/can_bt_vote.sv
module can_bt_vote (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic rx_s,
  input  logic triple_sel,
  input  logic span_ok,
  input  logic cap_far,
  input  logic cap_near,
  input  logic samp_ev,
  input  logic bit_end,
  output logic smp_bit,
  output logic smp_stb,
  output logic bit_val,
  output logic bit_vld
);
  logic c_far, c_near;
  logic use_vote;
  logic decided;

  assign use_vote = triple_sel && span_ok;
  assign decided  = use_vote ? can_bt_pkg::vote3(c_far, c_near, rx_s) : rx_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      c_far <= 1'b1; c_near <= 1'b1; smp_bit <= 1'b1; smp_stb <= 1'b0;
      bit_val <= 1'b1; bit_vld <= 1'b0;
    end else if (!run) begin
      c_far <= 1'b1; c_near <= 1'b1; smp_bit <= 1'b1; smp_stb <= 1'b0;
      bit_val <= 1'b1; bit_vld <= 1'b0;
    end else begin
      if (cap_far)  c_far  <= rx_s;
      if (cap_near) c_near <= rx_s;
      if (samp_ev)  smp_bit <= decided;
      smp_stb <= samp_ev;
      if (bit_end)  bit_val <= smp_bit;
      bit_vld <= bit_end;
    end

  // R6: the sample strobe is a single-clock pulse
  assert_smp_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb |=> !smp_stb);
endmodule

// File: rtl/can_bt_idle.sv
module can_bt_idle #(
  parameter int unsigned IDLE_RUN = can_bt_pkg::IDLE_RUN_DEF,
  localparam int unsigned CNT_W   = $clog2(IDLE_RUN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic bit_done,
  input  logic bit_in,
  output logic ready,
  output logic idle
);
  logic [CNT_W-1:0] rec_cnt;

  assign idle = (rec_cnt == CNT_W'(IDLE_RUN));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rec_cnt <= '0; ready <= 1'b0;
    end else if (!run) begin
      rec_cnt <= '0; ready <= 1'b0;
    end else if (bit_done) begin
      if (!bit_in) rec_cnt <= '0;
      else if (!idle) begin
        rec_cnt <= rec_cnt + 1'b1;
        if (rec_cnt == CNT_W'(IDLE_RUN - 1)) ready <= 1'b1;
      end
    end

  // R9: a dominant bit empties the recessive run
  assert_dominant_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && bit_done && !bit_in) |=> (rec_cnt == '0 && !idle));
  // R8: ready holds while the block keeps running
  assert_ready_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && run) |=> ready);
endmodule

// File: rtl/can_bit_sampler.sv
module can_bit_sampler #(
  parameter int unsigned PRESC_W     = 8,
  parameter int unsigned SEG_W       = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned IDLE_RUN    = can_bt_pkg::IDLE_RUN_DEF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               rx_in,
  input  logic [PRESC_W-1:0] presc,
  input  logic [SEG_W-1:0]   prop_seg,
  input  logic [SEG_W-1:0]   ph1_seg,
  input  logic [SEG_W-1:0]   ph2_seg,
  input  logic               triple_sel,
  output logic               bit_val,
  output logic               bit_vld,
  output logic               smp_stb,
  output logic               bus_ready
);
  localparam int unsigned TQ_W = SEG_W + 2;

  logic rx_s, rx_fall, hsync, tq_tick;
  logic cap_far, cap_near, samp_ev, bit_end, span_ok;
  logic smp_bit, idle;

  assign hsync = run && rx_fall && (!bus_ready || idle);

  can_bt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .rx_raw(rx_in), .rx_s(rx_s), .rx_fall(rx_fall));

  can_bt_tq_gen #(.PRESC_W(PRESC_W)) u_tq (
    .clk(clk), .rst_n(rst_n), .run(run), .hsync(hsync), .presc(presc),
    .tq_tick(tq_tick));

  can_bt_seq #(.SEG_W(SEG_W), .TQ_W(TQ_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .run(run), .hsync(hsync), .tq_tick(tq_tick),
    .prop_seg(prop_seg), .ph1_seg(ph1_seg), .ph2_seg(ph2_seg),
    .cap_far(cap_far), .cap_near(cap_near), .samp_ev(samp_ev),
    .bit_end(bit_end), .span_ok(span_ok));

  can_bt_vote u_vote (
    .clk(clk), .rst_n(rst_n), .run(run), .rx_s(rx_s), .triple_sel(triple_sel),
    .span_ok(span_ok), .cap_far(cap_far), .cap_near(cap_near),
    .samp_ev(samp_ev), .bit_end(bit_end), .smp_bit(smp_bit),
    .smp_stb(smp_stb), .bit_val(bit_val), .bit_vld(bit_vld));

  can_bt_idle #(.IDLE_RUN(IDLE_RUN)) u_idle (
    .clk(clk), .rst_n(rst_n), .run(run), .bit_done(bit_end),
    .bit_in(smp_bit), .ready(bus_ready), .idle(idle));

  // R7: one strobe per bit, never two clocks in a row
  assert_vld_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_vld && ph2_seg != '0) |=> !bit_vld);
  // R7: the held value moves only with a strobe while running
  assert_stable_val_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run) && run && !bit_vld) |-> $stable(bit_val));
  // R8: ready can only appear together with a bit strobe
  assert_ready_with_vld_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_ready) |-> bit_vld);
  // R2: nothing is emitted while held
  assert_quiet_when_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run) |-> (!bit_vld && !smp_stb && !bus_ready));
endmodule

// File: tb/test_can_bit_sampler.sv
module test_can_bit_sampler;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0;
  logic rx_in = 1'b1;
  logic [7:0] presc = 8'd1;
  logic [3:0] prop_seg = 4'd2, ph1_seg = 4'd3, ph2_seg = 4'd2;
  logic triple_sel = 1'b0;
  logic bit_val, bit_vld, smp_stb, bus_ready;

  int total = 0, bad = 0, cyc = 0, c0 = 0, nv = 0, ns = 0;
  int log_v [64];
  int log_r [64];
  int log_c [64];
  int s_c   [64];
  bit finished = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  can_bit_sampler i_can_bit_sampler (
    .clk(clk), .rst_n(rst_n), .run(run), .rx_in(rx_in), .presc(presc),
    .prop_seg(prop_seg), .ph1_seg(ph1_seg), .ph2_seg(ph2_seg),
    .triple_sel(triple_sel), .bit_val(bit_val), .bit_vld(bit_vld),
    .smp_stb(smp_stb), .bus_ready(bus_ready));

  always @(negedge clk) begin
    if (bit_vld && nv < 64) begin
      log_v[nv] = int'(bit_val); log_r[nv] = int'(bus_ready); log_c[nv] = cyc; nv = nv + 1;
    end
    if (smp_stb && ns < 64) begin
      s_c[ns] = cyc; ns = ns + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic v, input int glo, input int ghi, input int len, input bit mark);
    for (int o = 0; o < len; o++) begin
      @(negedge clk);
      if (mark && o == 0) c0 = cyc;
      if (mark && o == 5) begin nv = 0; ns = 0; end
      rx_in = (o >= glo && o <= ghi) ? ~v : v;
    end
  endtask

  task automatic rest(input int n);
    rx_in = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    repeat (4) @(negedge clk);
    chk("R2 vld in reset", int'(bit_vld), 0);
    chk("R2 ready in reset", int'(bus_ready), 0);
    chk("R2 value in reset", int'(bit_val), 1);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk("R2 smp while held", int'(smp_stb), 0);
    chk("R2 strobes while held", nv + ns, 0);
  endtask

  task automatic t_ready;
    @(negedge clk); nv = 0; run = 1'b1;
    rest(12 * 16 + 20);
    chk("R8 pulses seen", int'(nv >= 12), 1);
    chk("R8 ready at 10th bit", log_r[9], 0);
    chk("R8 ready at 11th bit", log_r[10], 1);
    chk("R1 bit spacing 8Tq", log_c[1] - log_c[0], 16);
  endtask

  task automatic t_hold_and_restart;
    @(negedge clk); run = 1'b0;
    repeat (2) @(negedge clk);
    nv = 0; ns = 0;
    repeat (40) @(negedge clk);
    chk("R2 ready cleared by hold", int'(bus_ready), 0);
    chk("R2 no strobes while held", nv + ns, 0);
    run = 1'b1;
    rest(80);
    send_bit(1'b0, -1, -2, 16, 1'b1);
    rest(13 * 16);
    chk("R9 dominant bit value", log_v[0], 0);
    chk("R9 ready after 10 recessive", log_r[10], 0);
    chk("R9 ready after 11 recessive", log_r[11], 1);
  endtask

  task automatic t_hsync_timing;
    send_bit(1'b0, -1, -2, 16, 1'b1);
    rest(14 * 16);
    chk("R6 sample strobe cycle", s_c[0] - c0, 15);
    chk("R7 bit strobe cycle", log_c[0] - c0, 19);
    chk("R10 idle edge resynced value", log_v[0], 0);
  endtask

  task automatic frame5;
    send_bit(1'b0, -1, -2, 16, 1'b1);
    send_bit(1'b1, 11, 12, 16, 1'b0);
    send_bit(1'b1, 9, 10, 16, 1'b0);
    send_bit(1'b0, 11, 12, 16, 1'b0);
    send_bit(1'b1, 9, 12, 16, 1'b0);
    rest(14 * 16);
  endtask

  task automatic t_single;
    triple_sel = 1'b0;
    frame5;
    chk("R3 bit1 glitch at sample", log_v[1], 0);
    chk("R3 bit2 glitch before sample", log_v[2], 1);
    chk("R3 bit3 recessive at sample", log_v[3], 1);
    chk("R3 bit4", log_v[4], 0);
    chk("R10 no resync mid-frame", log_c[4] - log_c[0], 64);
  endtask

  task automatic t_triple;
    triple_sel = 1'b1;
    frame5;
    chk("R4 bit1 outvoted", log_v[1], 1);
    chk("R4 bit2 outvoted", log_v[2], 1);
    chk("R4 bit3 outvoted", log_v[3], 0);
    chk("R4 bit4 two of three", log_v[4], 0);
    chk("R10 no resync mid-frame triple", log_c[4] - log_c[0], 64);
  endtask

  task automatic t_fallback;
    triple_sel = 1'b1; prop_seg = 4'd1; ph1_seg = 4'd1; ph2_seg = 4'd2;
    rest(15 * 16);
    send_bit(1'b0, -1, -2, 10, 1'b1);
    send_bit(1'b1, 5, 6, 10, 1'b0);
    send_bit(1'b1, -1, -2, 10, 1'b0);
    rest(14 * 10);
    chk("R5 single rule used", log_v[1], 0);
    chk("R5 clean bit", log_v[2], 1);
    chk("R1 bit spacing 5Tq", log_c[1] - log_c[0], 10);
  endtask

  task automatic t_presc;
    triple_sel = 1'b0; presc = 8'd3; prop_seg = 4'd2; ph1_seg = 4'd3; ph2_seg = 4'd2;
    rest(300);
    nv = 0;
    rest(130);
    chk("R1 pulses with slow Tq", int'(nv >= 3), 1);
    chk("R1 bit spacing presc 3", log_c[2] - log_c[1], 32);
  endtask

  initial begin
    t_reset;
    t_ready;
    t_hold_and_restart;
    t_hsync_timing;
    t_single;
    t_triple;
    t_fallback;
    t_presc;
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule